// File: doc/BRIEF.md
# Sequential Signed/Unsigned Integer Divider

This unit divides one integer by another over many clock cycles, one quotient bit per iteration, for the integer datapath of a load/store processor. A single start strobe captures the dividend, the divisor and a mode bit that selects two's-complement or plain magnitude interpretation. The unit then runs a restoring shift-and-subtract loop on one double-width register that holds the partial remainder in its upper half and the dividend and quotient bits in its lower half.

When the loop ends, the quotient is written into the LO result register and the remainder into the HI result register, with a one-cycle completion pulse. Both registers drive output ports at all times, so a later move-from operation reads them whenever it needs them. In signed mode the unit divides operand magnitudes and then corrects the signs. The quotient rounds toward zero and a nonzero remainder follows the sign of the dividend. A zero divisor raises no trap. It finishes in the usual number of cycles with defined results.

Top module: `seq_divider`

## Requirements
- R1: While reset is asserted and after it is released, busy_o and done_o are 0 and hi_o and lo_o are 0.
- R2: start_i is taken only while busy_o is 0. A start_i pulse while busy_o is 1 does not change the result of the division in progress.
- R3: After an accepted start, busy_o is 1 for exactly W+1 clock cycles. In the cycle after the last of these cycles, done_o is 1 for one cycle, busy_o is 0, and hi_o/lo_o show the new result.
- R4: With signed_i=0, lo_o is the truncated unsigned quotient and hi_o is the unsigned remainder, which is smaller than the divisor when the divisor is nonzero.
- R5: With signed_i=1 (operand bit W-1 is the sign), the quotient rounds toward zero and a nonzero remainder has the same sign as the dividend.
- R6: hi_o and lo_o change only in a cycle where done_o is 1. Between completions they hold their values, whatever the inputs do.
- R7: With a zero divisor, hi_o equals the dividend. lo_o is all ones, except in signed mode with a negative dividend, where it is 1.
- R8: In signed mode, the most negative dividend divided by -1 gives lo_o equal to the most negative value and hi_o equal to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, taken only while idle |
| signed_i | input | 1 | 1 selects two's-complement operands, 0 selects unsigned |
| dividend_i | input | W | Dividend, sampled with an accepted start |
| divisor_i | input | W | Divisor, sampled with an accepted start |
| busy_o | output | 1 | High while a division is in progress |
| done_o | output | 1 | One-cycle pulse when HI/LO are written |
| hi_o | output | W | HI register: remainder of the last division |
| lo_o | output | W | LO register: quotient of the last division |

## Verification
The checker checks these properties on every cycle:
- the exact busy length before each completion;
- the single-cycle completion pulse and that busy is low during it;
- that HI/LO change only on completion;
- the remainder sign in signed mode;
- the unsigned remainder bound;
- the zero-divisor remainder.

Only the bench's scenarios can show the following:
- the full quotient and remainder values against a reference model;
- that a start strobe sent during a division has no effect;
- the exact zero-divisor quotient;
- the most-negative-by-minus-one wrap;
- the reset state.

// File: rtl/div_pkg.sv
package div_pkg;

  typedef enum logic [1:0] {
    DV_IDLE = 2'd0,
    DV_RUN  = 2'd1,
    DV_FIN  = 2'd2
  } dv_state_e;

endpackage

// File: rtl/div_operand_prep.sv
// Converts the captured operands to magnitudes and reports their signs.
module div_operand_prep #(
  parameter int W = 32
) (
  input  logic         signed_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic [W-1:0] mag_a_o,
  output logic [W-1:0] mag_b_o,
  output logic         neg_a_o,
  output logic         neg_b_o
);

  always_comb begin
    neg_a_o = signed_i & dividend_i[W-1];
    neg_b_o = signed_i & divisor_i[W-1];
    mag_a_o = neg_a_o ? (~dividend_i + W'(1)) : dividend_i;
    mag_b_o = neg_b_o ? (~divisor_i + W'(1)) : divisor_i;
  end

endmodule

// File: rtl/div_step_core.sv
// Restoring shift-and-subtract engine on one double-width register.
module div_step_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         step_i,
  input  logic [W-1:0] mag_a_i,
  input  logic [W-1:0] mag_b_i,
  output logic [W-1:0] quot_mag_o,
  output logic [W-1:0] rem_mag_o,
  output logic         last_o
);

  localparam int RW = 2 * W;
  localparam int CW = (W > 1) ? $clog2(W) : 1;

  logic [RW-1:0] acc_q, acc_d;
  logic [W-1:0]  dvs_q, dvs_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [W:0]    trial;
  logic [W:0]    diff;
  logic [RW-1:0] acc_step;
  logic          acc_en;

  // Trial subtraction on the upper half after a one-bit left shift.
  always_comb begin
    trial = acc_q[RW-1:W-1];
    diff  = trial - {1'b0, dvs_q};
    if (diff[W]) begin
      acc_step = {acc_q[RW-2:0], 1'b0};
    end else begin
      acc_step = {diff[W-1:0], acc_q[W-2:0], 1'b1};
    end
  end

  always_comb begin
    acc_en = load_i | step_i;
    acc_d  = acc_q;
    dvs_d  = dvs_q;
    cnt_d  = cnt_q;
    if (load_i) begin
      acc_d = {{W{1'b0}}, mag_a_i};
      dvs_d = mag_b_i;
      cnt_d = '0;
    end else if (step_i) begin
      acc_d = acc_step;
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      dvs_q <= '0;
      cnt_q <= '0;
    end else if (acc_en) begin
      acc_q <= acc_d;
      dvs_q <= dvs_d;
      cnt_q <= cnt_d;
    end
  end

  assign quot_mag_o = acc_q[W-1:0];
  assign rem_mag_o  = acc_q[RW-1:W];
  assign last_o     = step_i && (cnt_q == CW'(W - 1));

endmodule

// File: rtl/div_sign_fix.sv
// Applies the recorded signs to quotient and remainder magnitudes.
module div_sign_fix #(
  parameter int W = 32
) (
  input  logic [W-1:0] quot_mag_i,
  input  logic [W-1:0] rem_mag_i,
  input  logic         neg_q_i,
  input  logic         neg_r_i,
  output logic [W-1:0] quot_o,
  output logic [W-1:0] rem_o
);

  always_comb begin
    quot_o = neg_q_i ? (~quot_mag_i + W'(1)) : quot_mag_i;
    rem_o  = neg_r_i ? (~rem_mag_i + W'(1)) : rem_mag_i;
  end

endmodule

// File: rtl/seq_divider.sv
module seq_divider
  import div_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         signed_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o
);

  dv_state_e    state_q, state_d;
  logic         load, step, last;
  logic [W-1:0] mag_a, mag_b, quot_mag, rem_mag, quot, rem;
  logic         neg_a, neg_b;
  logic         neg_q_q, neg_q_d, neg_r_q, neg_r_d;
  logic [W-1:0] hi_q, hi_d, lo_q, lo_d;
  logic         res_en, done_q, done_d;

  div_operand_prep #(.W(W)) u_prep (
    .signed_i   (signed_i),
    .dividend_i (dividend_i),
    .divisor_i  (divisor_i),
    .mag_a_o    (mag_a),
    .mag_b_o    (mag_b),
    .neg_a_o    (neg_a),
    .neg_b_o    (neg_b)
  );

  div_step_core #(.W(W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load),
    .step_i     (step),
    .mag_a_i    (mag_a),
    .mag_b_i    (mag_b),
    .quot_mag_o (quot_mag),
    .rem_mag_o  (rem_mag),
    .last_o     (last)
  );

  div_sign_fix #(.W(W)) u_fix (
    .quot_mag_i (quot_mag),
    .rem_mag_i  (rem_mag),
    .neg_q_i    (neg_q_q),
    .neg_r_i    (neg_r_q),
    .quot_o     (quot),
    .rem_o      (rem)
  );

  // Control
  always_comb begin
    load    = (state_q == DV_IDLE) && start_i;
    step    = (state_q == DV_RUN);
    res_en  = (state_q == DV_FIN);
    state_d = state_q;
    unique case (state_q)
      DV_IDLE: if (start_i) state_d = DV_RUN;
      DV_RUN:  if (last)    state_d = DV_FIN;
      DV_FIN:               state_d = DV_IDLE;
      default:              state_d = DV_IDLE;
    endcase
    neg_q_d = neg_a ^ neg_b;
    neg_r_d = neg_a;
    hi_d    = rem;
    lo_d    = quot;
    done_d  = res_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= DV_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      neg_q_q <= 1'b0;
      neg_r_q <= 1'b0;
    end else if (load) begin
      neg_q_q <= neg_q_d;
      neg_r_q <= neg_r_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (res_en) begin
      hi_q <= hi_d;
      lo_q <= lo_d;
    end
  end

  assign busy_o = (state_q != DV_IDLE);
  assign done_o = done_q;
  assign hi_o   = hi_q;
  assign lo_o   = lo_q;

endmodule

// File: rtl/div_checker.sv
module div_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start_i,
  input logic         signed_i,
  input logic [W-1:0] dividend_i,
  input logic [W-1:0] divisor_i,
  input logic         busy_o,
  input logic         done_o,
  input logic [W-1:0] hi_o,
  input logic [W-1:0] lo_o
);

  localparam int BW = $clog2(W + 2) + 1;

  logic [BW-1:0] busy_run;
  logic          cap_sgn;
  logic [W-1:0]  cap_a, cap_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_run <= '0;
    end else if (busy_o) begin
      busy_run <= busy_run + BW'(1);
    end else begin
      busy_run <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_sgn <= 1'b0;
      cap_a   <= '0;
      cap_b   <= '0;
    end else if (!busy_o && start_i) begin
      cap_sgn <= signed_i;
      cap_a   <= dividend_i;
      cap_b   <= divisor_i;
    end
  end

  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> busy_o);

  assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (busy_run == BW'(W + 1)));

  assert_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_idle_at_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  assert_rem_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !cap_sgn && (cap_b != '0)) |-> (hi_o < cap_b));

  assert_rem_sign_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && cap_sgn && (hi_o != '0)) |-> (hi_o[W-1] == cap_a[W-1]));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(hi_o) && $stable(lo_o)));

  assert_zero_div_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && (cap_b == '0)) |-> (hi_o == cap_a));

endmodule

bind seq_divider div_checker #(.W(W)) u_div_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .signed_i   (signed_i),
  .dividend_i (dividend_i),
  .divisor_i  (divisor_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .hi_o       (hi_o),
  .lo_o       (lo_o)
);

// File: tb/seq_divider_bench.sv
`timescale 1ns/1ps
module seq_divider_bench;

  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic         signed_i = 1'b0;
  logic [W-1:0] dividend_i = '0;
  logic [W-1:0] divisor_i = '0;
  logic         busy_o, done_o;
  logic [W-1:0] hi_o, lo_o;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  seq_divider #(.W(W)) u_seq_divider (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .signed_i   (signed_i),
    .dividend_i (dividend_i),
    .divisor_i  (divisor_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .hi_o       (hi_o),
    .lo_o       (lo_o)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference model: returns {hi, lo}
  function automatic logic [2*W-1:0] model(input logic [W-1:0] a, input logic [W-1:0] b,
                                           input logic s);
    logic [W-1:0] q, r;
    longint sa, sb, sq, sr;
    if (b == '0) begin
      r = a;
      q = (s && a[W-1]) ? W'(1) : '1;
    end else if (!s) begin
      q = a / b;
      r = a % b;
    end else begin
      sa = longint'($signed(a));
      sb = longint'($signed(b));
      sq = sa / sb;
      sr = sa % sb;
      q = sq[W-1:0];
      r = sr[W-1:0];
    end
    return {r, q};
  endfunction

  task automatic do_div(input logic [W-1:0] a, input logic [W-1:0] b, input logic s,
                        input bit inject, input string req);
    logic [2*W-1:0] exp;
    int n;
    @(negedge clk);
    dividend_i = a; divisor_i = b; signed_i = s; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R3 busy after start", W'(busy_o), W'(1));
    n = 1;
    while (!done_o && n < 100) begin
      if (inject && n == 4) begin
        dividend_i = ~a; divisor_i = b + W'(3); signed_i = ~s; start_i = 1'b1;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
      n++;
    end
    start_i = 1'b0;
    chk("R3 latency", W'(n), W'(W + 2));
    chk("R3 idle at done", W'(busy_o), W'(0));
    exp = model(a, b, s);
    chk({req, " lo"}, lo_o, exp[W-1:0]);
    chk({req, " hi"}, hi_o, exp[2*W-1:W]);
  endtask

  initial begin
    #(200000 * 20);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [W-1:0] hk, lk;
    void'($urandom(32'd2024));
    #35;
    // R1 reset state
    chk("R1 busy", W'(busy_o), W'(0));
    chk("R1 done", W'(done_o), W'(0));
    chk("R1 hi", hi_o, '0);
    chk("R1 lo", lo_o, '0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 hi after release", hi_o, '0);

    // R4 unsigned directed
    do_div(32'd100, 32'd7, 1'b0, 0, "R4");
    do_div(32'hFFFF_FFFF, 32'd1, 1'b0, 0, "R4");
    do_div(32'd5, 32'd9, 1'b0, 0, "R4");
    do_div(32'h8000_0000, 32'hFFFF_FFFF, 1'b0, 0, "R4");
    // R5 signed directed
    do_div(-32'sd7, 32'sd2, 1'b1, 0, "R5");
    do_div(32'sd7, -32'sd2, 1'b1, 0, "R5");
    do_div(-32'sd7, -32'sd2, 1'b1, 0, "R5");
    do_div(-32'sd6, 32'sd3, 1'b1, 0, "R5");
    // R7 zero divisor
    do_div(32'd1234, 32'd0, 1'b0, 0, "R7");
    do_div(32'd1234, 32'd0, 1'b1, 0, "R7");
    do_div(-32'sd50, 32'd0, 1'b1, 0, "R7");
    // R8 most negative by -1
    do_div(32'h8000_0000, 32'hFFFF_FFFF, 1'b1, 0, "R8");
    chk("R8 lo value", lo_o, 32'h8000_0000);
    chk("R8 hi value", hi_o, 32'h0);
    // R2 start during busy ignored
    do_div(32'd999_999, 32'd13, 1'b0, 1, "R2");
    do_div(-32'sd12345, 32'sd77, 1'b1, 1, "R2");

    // R6 hold while idle with changing inputs
    hk = hi_o; lk = lo_o;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      dividend_i = $urandom; divisor_i = $urandom; signed_i = i[0];
    end
    chk("R6 hi hold", hi_o, hk);
    chk("R6 lo hold", lo_o, lk);

    // Random mix
    for (int i = 0; i < 60; i++) begin
      logic [W-1:0] a, b;
      a = $urandom;
      b = $urandom;
      if (i % 3 == 0) b = b >> ($urandom % 31);
      if (i % 11 == 0) b = '0;
      do_div(a, b, i[0], (i % 7) == 0, i[0] ? "R5 random" : "R4 random");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule